// File: doc/BRIEF.md
# Byte-Lane Write Decode and Flow-Through SRAM Data Path

This block is the data side of a synchronous static RAM whose words are split into byte lanes. Each lane holds eight data bits and one parity bit. At every rising clock edge the block captures the word address, the chip-select state, the write controls and the write data. It then commits any lane writes into the behavioural array at the following edge, so the write times itself. The address sequencing that feeds the word address is outside this block.

Two levels of write control exist. A global write strobe writes every lane and overrides everything else. A byte-write enable passes the per-lane selects to the array, and when it is inactive those selects are ignored. Read data comes straight from the array, addressed by the captured address, with no output register. It is therefore valid in the same cycle as the edge that captured the address. The output drivers are enabled only when the asynchronous output enable is low, the chip was selected at the last edge, and no write is pending. A sleep input freezes all clocked state while it is high.

Top module: `sram_bytelane_core`

## Requirements
- R1: When `sel` is high and `gw_n` is low at a clock edge where `sleep` is low, all lanes of the addressed word are written, whatever the values of `bwe_n` and `bw_n`.
- R2: When `sel` is high, `gw_n` is high and `bwe_n` is low at an edge, each lane i with `bw_n[i]` low is written and every other lane of the word keeps its old contents.
- R3: When `gw_n` and `bwe_n` are both high at an edge, no lane is written, whatever the value of `bw_n`.
- R4: Lane i consists of data bits `wdata[8i+7:8i]` and parity bit `wpar[i]`, and reads back on `rdata[8i+7:8i]` and `rpar[i]`.
- R5: In the cycle after an edge that captured a write of at least one lane, `q_en` is low.
- R6: An address captured at an edge with no write drives its stored word onto `rdata`/`rpar` in that same cycle, before the next edge. A read that follows a write to the same address shows the newly written lanes merged with the unchanged old lanes.
- R7: `q_en` is high only when `oe_n` is low, with no clock edge needed for that input, and `sel` was high at the last edge. A write presented while `sel` is low changes nothing.
- R8: While `sleep` is high at an edge, nothing is captured and no lane is written. A write presented during sleep is lost and stored data is kept.
- R9: After reset, `q_en` is low and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| sleep | input | 1 | High freezes all clocked state |
| sel | input | 1 | Chip selected, already combined from the enables |
| addr | input | AW | Word address from the burst sequencer |
| gw_n | input | 1 | Global write strobe, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| wdata | input | LANES*DATA_BITS | Write data, eight bits per lane |
| wpar | input | LANES | Write parity, one bit per lane |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*DATA_BITS | Flow-through read data |
| rpar | output | LANES | Flow-through read parity |
| q_en | output | 1 | High when the outputs drive; low stands for high impedance |

## Verification
Two events share one edge: a captured write commits into the array, and a read of the same word is captured and must show the merged result at once. The bench provokes this by following every write directly with a read of the same address. It compares the result with a lane-by-lane shadow model. In the cycle between those two edges, the output disable caused by the pending write is judged against the write mask that the bench computes itself. All 64 combinations of global strobe, byte enable and lane selects are swept in this way.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
   typedef enum logic [1:0] {
      WR_NONE   = 2'd0,
      WR_BYTES  = 2'd1,
      WR_GLOBAL = 2'd2
   } wr_kind_e;
endpackage

// File: rtl/sbl_we_decode.sv
module sbl_we_decode #(
   parameter int LANES = 4
) (
   input  logic             sel,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bw_n,
   output logic [LANES-1:0] lane_we
);
   import sbl_pkg::*;

   wr_kind_e kind;

   always_comb begin
      kind = WR_NONE;
      if (sel) begin
         if (!gw_n)
            kind = WR_GLOBAL;
         else if (!bwe_n && (~bw_n != '0))
            kind = WR_BYTES;
      end
   end

   always_comb begin
      case (kind)
         WR_GLOBAL: lane_we = '1;
         WR_BYTES:  lane_we = ~bw_n;
         default:   lane_we = '0;
      endcase
   end
endmodule

// File: rtl/sbl_in_stage.sv
module sbl_in_stage #(
   parameter int LANES = 4,
   parameter int LW    = 9,
   parameter int AW    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hold,
   input  logic                sel,
   input  logic [AW-1:0]       addr,
   input  logic [LANES-1:0]    lane_we,
   input  logic [LANES*LW-1:0] wword,
   output logic                sel_q,
   output logic [AW-1:0]       addr_q,
   output logic [LANES-1:0]    we_q,
   output logic [LANES*LW-1:0] wword_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= 1'b0;
         addr_q  <= '0;
         we_q    <= '0;
         wword_q <= '0;
      end else if (!hold) begin
         sel_q   <= sel;
         addr_q  <= addr;
         we_q    <= lane_we;
         wword_q <= wword;
      end
   end
endmodule

// File: rtl/sbl_array.sv
module sbl_array #(
   parameter int LANES = 4,
   parameter int LW    = 9,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                hold,
   input  logic [AW-1:0]       addr,
   input  logic [LANES-1:0]    we,
   input  logic [LANES*LW-1:0] wword,
   output logic [LANES*LW-1:0] rword
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LW-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (!hold && we[g])
            cells[addr] <= wword[g*LW +: LW];
      end

      assign rword[g*LW +: LW] = cells[addr];
   end
endmodule

// File: rtl/sram_bytelane_core.sv
module sram_bytelane_core #(
   parameter int LANES     = 4,
   parameter int DATA_BITS = 8,
   parameter int DEPTH     = 256,
   localparam int LW       = DATA_BITS + 1,
   localparam int AW       = $clog2(DEPTH),
   localparam int DW       = LANES * DATA_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep,
   input  logic             sel,
   input  logic [AW-1:0]    addr,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bw_n,
   input  logic [DW-1:0]    wdata,
   input  logic [LANES-1:0] wpar,
   input  logic             oe_n,
   output logic [DW-1:0]    rdata,
   output logic [LANES-1:0] rpar,
   output logic             q_en
);
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (DATA_BITS < 1) begin : g_bad_width
      $error("DATA_BITS must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic [LANES-1:0]    lane_we;
   logic [LANES-1:0]    lane_we_q;
   logic                sel_q;
   logic [AW-1:0]       addr_q;
   logic [LANES*LW-1:0] wword, wword_q, rword;

   for (genvar g = 0; g < LANES; g++) begin : g_pack
      assign wword[g*LW +: LW]      = {wpar[g], wdata[g*DATA_BITS +: DATA_BITS]};
      assign rdata[g*DATA_BITS +: DATA_BITS] = rword[g*LW +: DATA_BITS];
      assign rpar[g]                = rword[g*LW + DATA_BITS];
   end

   sbl_we_decode #(.LANES(LANES)) u_dec (
      .sel     (sel),
      .gw_n    (gw_n),
      .bwe_n   (bwe_n),
      .bw_n    (bw_n),
      .lane_we (lane_we)
   );

   sbl_in_stage #(.LANES(LANES), .LW(LW), .AW(AW)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (sleep),
      .sel     (sel),
      .addr    (addr),
      .lane_we (lane_we),
      .wword   (wword),
      .sel_q   (sel_q),
      .addr_q  (addr_q),
      .we_q    (lane_we_q),
      .wword_q (wword_q)
   );

   sbl_array #(.LANES(LANES), .LW(LW), .DEPTH(DEPTH)) u_arr (
      .clk   (clk),
      .hold  (sleep),
      .addr  (addr_q),
      .we    (lane_we_q),
      .wword (wword_q),
      .rword (rword)
   );

   assign q_en = !oe_n && sel_q && (lane_we_q == '0);
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker #(
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sleep,
   input logic             sel,
   input logic             gw_n,
   input logic             bwe_n,
   input logic             oe_n,
   input logic             q_en,
   input logic [LANES-1:0] we_q
);
   // R1: global strobe selects every lane
   a_r1_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !gw_n && !sleep) |=> (we_q == {LANES{1'b1}}));

   // R3: byte selects blocked when the byte enable is off
   a_r3_bytes_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (gw_n && bwe_n && !sleep) |=> (we_q == '0));

   // R7: no write while deselected
   a_r7_desel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && !sleep) |=> (we_q == '0));

   // R5: pending write turns drivers off
   a_r5_write_kills_out: assert property (@(posedge clk) disable iff (!rst_n)
      (we_q != '0) |-> !q_en);

   // R7: output enable high keeps drivers off
   a_r7_oe_gates_out: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !q_en);

   // R8: sleep freezes the captured write state
   a_r8_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> $stable(we_q));
endmodule

bind sram_bytelane_core sbl_checker #(.LANES(LANES)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .sleep (sleep),
   .sel   (sel),
   .gw_n  (gw_n),
   .bwe_n (bwe_n),
   .oe_n  (oe_n),
   .q_en  (q_en),
   .we_q  (lane_we_q)
);

// File: tb/tb_sram_bytelane_core.sv
`timescale 1ns/100ps
module tb_sram_bytelane_core;
   localparam int LANES = 4;
   localparam int DB    = 8;
   localparam int DEPTH = 16;
   localparam int AW    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep = 1'b0, sel = 1'b0, gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [LANES-1:0] bw_n = '1, wpar = '0, rpar;
   logic [LANES*DB-1:0] wdata = '0, rdata;
   logic q_en;

   int checks = 0, fails = 0;
   bit done = 0;

   logic [LANES*DB-1:0] m_data [DEPTH];
   logic [LANES-1:0]    m_par  [DEPTH];

   always #2.5 clk = ~clk;

   sram_bytelane_core #(.LANES(LANES), .DATA_BITS(DB), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel(sel), .addr(addr),
      .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .wdata(wdata), .wpar(wpar),
      .oe_n(oe_n), .rdata(rdata), .rpar(rpar), .q_en(q_en));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [LANES-1:0] exp_mask(input logic s, input logic g,
                                                 input logic b, input logic [LANES-1:0] w);
      if (!s) return '0;
      if (!g) return '1;
      if (!b) return ~w;
      return '0;
   endfunction

   task automatic idle();
      gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1; sel = 1'b1;
   endtask

   // starts and ends at a falling edge
   task automatic wr(input string req, input logic s, input logic [AW-1:0] a,
                     input logic g, input logic b, input logic [LANES-1:0] w,
                     input logic [LANES*DB-1:0] d, input logic [LANES-1:0] p);
      logic [LANES-1:0] m;
      m = exp_mask(s, g, b, w);
      sel = s; addr = a; gw_n = g; bwe_n = b; bw_n = w; wdata = d; wpar = p;
      @(negedge clk);
      chk({req, " R5 q_en during write cycle"}, 64'(q_en), 64'(s && (m == '0)));
      idle();
      for (int i = 0; i < LANES; i++) begin
         if (m[i]) begin
            m_data[a][i*DB +: DB] = d[i*DB +: DB];
            m_par[a][i] = p[i];
         end
      end
   endtask

   task automatic rd(input string req, input logic [AW-1:0] a);
      idle(); addr = a;
      @(negedge clk);
      chk({req, " R6 q_en on read"}, 64'(q_en), 64'd1);
      chk({req, " R6 read word"}, {28'd0, rpar, rdata}, {28'd0, m_par[a], m_data[a]});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 q_en after reset", 64'(q_en), 64'd0);

      // fill every word with a global write (R1)
      for (int a = 0; a < DEPTH; a++)
         wr("R1 fill", 1'b1, AW'(a), 1'b0, 1'b1, '1, 32'h1357_0000 + 32'(a * 32'h0101), 4'(a));
      for (int a = 0; a < DEPTH; a++)
         rd("R1 fill readback", AW'(a));

      // sweep every write-control combination (R1 R2 R3)
      for (int c = 0; c < 64; c++) begin
         logic [AW-1:0] a;
         logic [31:0] d;
         a = AW'(c % DEPTH);
         d = 32'h9E37_79B1 * 32'(c + 1);
         wr(c[5] ? (c[4] ? "R3 sweep" : "R2 sweep") : "R1 sweep", 1'b1, a,
            c[5], c[4], c[3:0], d, c[3:0] ^ 4'hA);
         rd(c[5] ? (c[4] ? "R3 sweep" : "R2 sweep") : "R1 sweep", a);
      end

      // lane mapping: lane 2 only (R4)
      wr("R4 lane2", 1'b1, 4'd5, 1'b1, 1'b0, 4'b1011, 32'hFFAA_FFFF, 4'b0100);
      rd("R4 lane2", 4'd5);
      chk("R4 lane2 data bits 23:16", 64'(rdata[23:16]), 64'hAA);
      chk("R4 lane2 parity bit 2", 64'(rpar[2]), 64'd1);

      // deselected write is ignored (R7)
      wr("R7 deselected", 1'b0, 4'd6, 1'b0, 1'b0, 4'b0000, 32'hDEAD_BEEF, 4'hF);
      rd("R7 deselected readback", 4'd6);

      // output enable acts without a clock edge (R7)
      oe_n = 1'b1; #1;
      chk("R7 oe_n high", 64'(q_en), 64'd0);
      oe_n = 1'b0; #1;
      chk("R7 oe_n low", 64'(q_en), 64'd1);

      // write during sleep is lost (R8)
      sleep = 1'b1; sel = 1'b1; addr = 4'd7; gw_n = 1'b0; wdata = 32'h0BAD_F00D; wpar = 4'h5;
      @(negedge clk);
      @(negedge clk);
      chk("R8 q_en held in sleep", 64'(q_en), 64'd1);
      idle(); sleep = 1'b0;
      rd("R8 after sleep", 4'd7);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule